// File: doc/BRIEF.md
# Product-Term Sum and Polarity Cell

This block is the combinational logic core of one macrocell in a programmable-logic fabric. It receives a shared vector of input signals and a static configuration. From these it builds five AND product terms. Each term can take any input in its true form, its complement form, or not at all. An allocation bit for each term routes that term either into the cell's OR sum or out to a control port. Control-port terms can then drive clock enables, resets or output enables elsewhere in the macrocell.

The local OR sum is merged with a cascade input from the neighbouring cell. The merged value leaves the cell on the cascade output, so a chain of cells can build one wide sum-of-products. The same merged value then passes through an XOR stage. The second XOR operand can be constant low, constant high, or a chosen product term. Constant high gives output polarity inversion. A product term as the operand supports compare-style or toggle-style functions.

There is no clock and no state. The configuration inputs are expected to hold still while the cell is in use.

Top module: `pterm_cell`

## Requirements
- R1: Product term k (k = 0..4) is the AND of selected literals. Bit k*N_IN+j of `lit_true` includes `in_vec[j]`, and the same bit of `lit_comp` includes `~in_vec[j]`.
- R2: A product term with no literal selected in either mask evaluates to 1.
- R3: A product term that selects both the true and the complement literal of the same input evaluates to 0, for every input vector.
- R4: When `sum_alloc[k]` is 1, term k feeds the OR sum and `ctrl_pt[k]` is 0. When `sum_alloc[k]` is 0, term k is excluded from the sum and appears on `ctrl_pt[k]`.
- R5: `casc_out` equals the OR of all allocated terms ORed with `casc_in`. A high `casc_in` always forces `casc_out` high.
- R6: With `xor_mode` = 2'b00, `cell_out` equals `casc_out`.
- R7: With `xor_mode` = 2'b01, `cell_out` equals the inverse of `casc_out`.
- R8: With `xor_mode[1]` = 1, `cell_out` equals `casc_out` XOR term number `xor_pt`. An `xor_pt` value of 5 or above selects a constant 0 operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_vec | input | N_IN (8) | Shared input signals seen by every product term |
| lit_true | input | 5*N_IN (40) | True-literal masks; bits k*N_IN..k*N_IN+N_IN-1 belong to term k |
| lit_comp | input | 5*N_IN (40) | Complement-literal masks, same layout as lit_true |
| sum_alloc | input | 5 | 1 routes term k into the OR sum, 0 routes it to ctrl_pt |
| xor_mode | input | 2 | 00 constant 0, 01 constant 1, 1x product term operand |
| xor_pt | input | 3 | Index of the product term used as the XOR operand |
| casc_in | input | 1 | Sum arriving from the neighbouring cell |
| casc_out | output | 1 | Local sum ORed with casc_in, taken before the XOR |
| cell_out | output | 1 | XOR stage result |
| ctrl_pt | output | 5 | Terms not allocated to the sum, zero where allocated |

## Verification
The hardest case to reach from the ports is a product term that is exactly 1 for only a few input vectors. With random masks on eight inputs almost every term is stuck at 0, so the sum and the XOR operand never change. The bench therefore draws sparse masks, typically one or two literals per term, and applies every one of the 256 input vectors with both cascade levels to each configuration. It adds directed configurations for empty terms, contradictory terms and an out-of-range XOR index.

// File: rtl/pterm_pkg.sv
package pterm_pkg;

  // Second operand choice for the polarity stage.
  typedef enum logic [1:0] {
    XS_ZERO  = 2'b00,
    XS_ONE   = 2'b01,
    XS_TERM  = 2'b10,
    XS_TERM2 = 2'b11
  } xor_sel_e;

  // A literal is violated when it is selected and the input disagrees.
  function automatic logic lit_miss(input logic use_t, input logic use_c, input logic x);
    return (use_t & ~x) | (use_c & x);
  endfunction

  function automatic logic const_operand(input xor_sel_e sel);
    return (sel == XS_ONE);
  endfunction

endpackage

// File: rtl/pterm_and.sv
module pterm_and #(
  parameter int N_IN = 8
) (
  input  logic [N_IN-1:0] in_vec,
  input  logic [N_IN-1:0] use_true,
  input  logic [N_IN-1:0] use_comp,
  output logic            term
);
  import pterm_pkg::*;

  logic [N_IN-1:0] miss;

  genvar j;
  generate
    for (j = 0; j < N_IN; j++) begin : g_lit
      assign miss[j] = lit_miss(use_true[j], use_comp[j], in_vec[j]);
    end
  endgenerate

  // An empty mask has no misses and yields 1.
  assign term = ~|miss;

endmodule

// File: rtl/pterm_sum.sv
module pterm_sum #(
  parameter int N_TERM = 5
) (
  input  logic [N_TERM-1:0] terms,
  input  logic [N_TERM-1:0] alloc,
  input  logic              casc_in,
  output logic              local_sum,
  output logic              merged_sum,
  output logic [N_TERM-1:0] ctrl
);
  assign local_sum  = |(terms & alloc);
  assign merged_sum = local_sum | casc_in;
  assign ctrl       = terms & ~alloc;
endmodule

// File: rtl/pterm_xor.sv
module pterm_xor #(
  parameter int N_TERM = 5,
  parameter int IDX_W  = 3
) (
  input  logic              sum_in,
  input  logic [N_TERM-1:0] terms,
  input  logic [1:0]        mode,
  input  logic [IDX_W-1:0]  idx,
  output logic              operand,
  output logic              result
);
  import pterm_pkg::*;

  function automatic logic pick_term(input logic [N_TERM-1:0] t, input logic [IDX_W-1:0] k);
    logic r;
    r = 1'b0;
    for (int i = 0; i < N_TERM; i++) begin
      if (k == IDX_W'(i)) r = t[i];
    end
    return r;
  endfunction

  xor_sel_e sel;
  assign sel = xor_sel_e'(mode);

  always_comb begin
    if (mode[1]) operand = pick_term(terms, idx);
    else         operand = const_operand(sel);
  end

  assign result = sum_in ^ operand;

endmodule

// File: rtl/pterm_cell.sv
module pterm_cell #(
  parameter int N_IN   = 8,
  parameter int N_TERM = 5,
  parameter int IDX_W  = (N_TERM > 1) ? $clog2(N_TERM) : 1,
  parameter int MASK_W = N_TERM * N_IN
) (
  input  logic [N_IN-1:0]   in_vec,
  input  logic [MASK_W-1:0] lit_true,
  input  logic [MASK_W-1:0] lit_comp,
  input  logic [N_TERM-1:0] sum_alloc,
  input  logic [1:0]        xor_mode,
  input  logic [IDX_W-1:0]  xor_pt,
  input  logic              casc_in,
  output logic              casc_out,
  output logic              cell_out,
  output logic [N_TERM-1:0] ctrl_pt
);

  // Named internal events, visible to the bound checker.
  logic [N_TERM-1:0] pt_vec;
  logic              local_sum;
  logic              xor_opd;

  genvar k;
  generate
    for (k = 0; k < N_TERM; k++) begin : g_term
      pterm_and #(.N_IN(N_IN)) u_and (
        .in_vec  (in_vec),
        .use_true(lit_true[k*N_IN +: N_IN]),
        .use_comp(lit_comp[k*N_IN +: N_IN]),
        .term    (pt_vec[k])
      );
    end
  endgenerate

  pterm_sum #(.N_TERM(N_TERM)) u_sum (
    .terms     (pt_vec),
    .alloc     (sum_alloc),
    .casc_in   (casc_in),
    .local_sum (local_sum),
    .merged_sum(casc_out),
    .ctrl      (ctrl_pt)
  );

  pterm_xor #(.N_TERM(N_TERM), .IDX_W(IDX_W)) u_xor (
    .sum_in (casc_out),
    .terms  (pt_vec),
    .mode   (xor_mode),
    .idx    (xor_pt),
    .operand(xor_opd),
    .result (cell_out)
  );

endmodule

// File: rtl/pterm_cell_chk.sv
module pterm_cell_chk #(
  parameter int N_TERM = 5
) (
  input logic              casc_in,
  input logic              casc_out,
  input logic              cell_out,
  input logic              local_sum,
  input logic              xor_opd,
  input logic [N_TERM-1:0] ctrl_pt,
  input logic [N_TERM-1:0] sum_alloc,
  input logic [1:0]        xor_mode
);
  logic known;
  assign known = !$isunknown({casc_in, casc_out, cell_out, local_sum, xor_opd,
                              ctrl_pt, sum_alloc, xor_mode});

  always_comb begin
    if (known) begin
      AST_CASC_FORCES: assert (!casc_in || casc_out) else $error("cascade input lost"); // R5
      AST_LOCAL_REACHES: assert (!local_sum || casc_out) else $error("local sum lost"); // R5
      AST_CTRL_EXCLUSIVE: assert ((ctrl_pt & sum_alloc) == '0) else $error("allocated term on control port"); // R4
      AST_PASS_THROUGH: assert (xor_mode != 2'b00 || cell_out == casc_out) else $error("pass mode differs"); // R6
      AST_INVERT: assert (xor_mode != 2'b01 || cell_out != casc_out) else $error("invert mode differs"); // R7
      AST_TERM_OPERAND: assert (!xor_mode[1] || cell_out == (casc_out ^ xor_opd)) else $error("term operand mismatch"); // R8
    end
  end
endmodule

bind pterm_cell pterm_cell_chk #(.N_TERM(N_TERM)) u_chk (
  .casc_in  (casc_in),
  .casc_out (casc_out),
  .cell_out (cell_out),
  .local_sum(local_sum),
  .xor_opd  (xor_opd),
  .ctrl_pt  (ctrl_pt),
  .sum_alloc(sum_alloc),
  .xor_mode (xor_mode)
);

// File: tb/pterm_cell_bench.sv
module pterm_cell_bench;
  localparam int NI = 8;
  localparam int NT = 5;
  localparam int MW = NI * NT;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [NI-1:0] in_vec;
  logic [MW-1:0] lt, lc;
  logic [NT-1:0] alloc;
  logic [1:0]    xmode;
  logic [2:0]    xpt;
  logic          cin;
  logic          casc_out, cell_out;
  logic [NT-1:0] ctrl_pt;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  pterm_cell u_pterm_cell (
    .in_vec(in_vec), .lit_true(lt), .lit_comp(lc), .sum_alloc(alloc),
    .xor_mode(xmode), .xor_pt(xpt), .casc_in(cin),
    .casc_out(casc_out), .cell_out(cell_out), .ctrl_pt(ctrl_pt)
  );

  // Reference term: 0 as soon as one chosen literal disagrees (R1, R2, R3).
  function automatic logic ref_term(input int t, input logic [NI-1:0] x);
    for (int j = 0; j < NI; j++) begin
      if (lt[t*NI+j] == 1'b1 && x[j] == 1'b0) return 1'b0;
      if (lc[t*NI+j] == 1'b1 && x[j] == 1'b1) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic check_bit(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s in=%0h cin=%0b actual=%0b expected=%0b", req, what, in_vec, cin, act, exp);
    end
  endtask

  task automatic check_vec(input string req, input logic [NT-1:0] act, input logic [NT-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s ctrl_pt in=%0h actual=%0b expected=%0b", req, in_vec, act, exp);
    end
  endtask

  // Apply all inputs and both cascade levels to the present configuration.
  task automatic sweep(input string req);
    for (int v = 0; v < (1 << NI); v++) begin
      for (int c = 0; c < 2; c++) begin
        logic [NT-1:0] pt;
        logic s, opd;
        @(posedge clk);
        in_vec <= NI'(v);
        cin    <= c[0];
        @(negedge clk);
        for (int t = 0; t < NT; t++) pt[t] = ref_term(t, in_vec);
        s = cin;
        for (int t = 0; t < NT; t++) if (alloc[t]) s = s | pt[t];
        if (xmode == 2'b00)      opd = 1'b0;
        else if (xmode == 2'b01) opd = 1'b1;
        else if (xpt < 3'(NT))   opd = pt[xpt];
        else                     opd = 1'b0;
        check_bit({req, " R5"}, "casc_out", casc_out, s);
        check_bit({req, " R6 R7 R8"}, "cell_out", cell_out, s ^ opd);
        check_vec({req, " R4"}, ctrl_pt, pt & ~alloc);
      end
    end
  endtask

  function automatic logic [MW-1:0] sparse_mask();
    logic [63:0] a, b, c;
    a = {$urandom, $urandom};
    b = {$urandom, $urandom};
    c = {$urandom, $urandom};
    return MW'(a & b & c);
  endfunction

  initial begin
    in_vec = '0; lt = '0; lc = '0; alloc = '0; xmode = 2'b00; xpt = 3'd0; cin = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // Reset-like state: nothing allocated, empty terms all on ctrl_pt.
    check_bit("R5", "idle casc_out", casc_out, 1'b0);
    check_vec("R2 R4", ctrl_pt, 5'b11111);

    // R2: empty terms are 1; all allocated, so sum is always 1.
    lt = '0; lc = '0; alloc = 5'b11111; xmode = 2'b00;
    sweep("R2");

    // R3: every term contradicts itself on input 0..4; only cascade drives the sum.
    lt = '0; lc = '0;
    for (int t = 0; t < NT; t++) begin lt[t*NI+t] = 1'b1; lc[t*NI+t] = 1'b1; end
    alloc = 5'b11111; xmode = 2'b00;
    sweep("R3");

    // R1 with R7: single-literal terms, inversion enabled, mixed allocation.
    lt = '0; lc = '0;
    lt[0*NI+0] = 1'b1; lc[1*NI+1] = 1'b1; lt[2*NI+2] = 1'b1; lt[2*NI+3] = 1'b1;
    lc[3*NI+7] = 1'b1; lt[4*NI+6] = 1'b1;
    alloc = 5'b01011; xmode = 2'b01;
    sweep("R1 R7");

    // R8: term operand, and an out-of-range index acting as 0.
    xmode = 2'b10; xpt = 3'd4;
    sweep("R8");
    xmode = 2'b11; xpt = 3'd6;
    sweep("R8 range");

    // Random sparse configurations across all modes.
    for (int n = 0; n < 36; n++) begin
      lt    = sparse_mask();
      lc    = sparse_mask();
      alloc = 5'($urandom);
      xmode = 2'($urandom);
      xpt   = 3'($urandom);
      sweep("R1 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule